// File: doc/BRIEF.md
# Masked-write GPIO bank controller

This block drives and samples a bank of 32 general-purpose pins from a small memory-mapped register port. Every pin owns one output-level bit and one direction bit. Both are kept in 16-bit halves, one half for pins 0 to 15 and one for pins 16 to 31.

A write carries its own per-bit enable. The upper sixteen bits of the write word choose which of the lower sixteen bits are stored. Software can therefore set, clear or turn around a single pin in one access, with no read-modify-write and no race between agents that share the bank. Pin inputs pass through a two-stage synchronizer and can be read back as one 32-bit word. A fixed nonzero identifier tells software which register layout is present.

The port takes an address, a select, a write strobe and write data. Read data is combinational from the address in the same cycle. Every access finishes in one cycle.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset, every output-level bit and every direction bit is 0, so `pin_out` and `pin_oe` are all zero and every pin is an input.
- R2: A write to a half-register at offsets 0x00, 0x04, 0x08 or 0x0C updates stored bit k (k = 0..15) from write-data bit k only when write-data bit k+16 is 1. All other bits keep their value. The change shows on the pins after the clock edge that takes the write.
- R3: Offset 0x00 holds the output levels of pins 0..15. Offset 0x04 holds pins 16..31, with bit n driving pin 16+n. `pin_out` shows the stored output levels.
- R4: Offset 0x08 holds the directions of pins 0..15 and offset 0x0C those of pins 16..31, with bit n controlling pin 16+n. `pin_oe` bit p is 1 (pin is an output) exactly when the direction bit of pin p is 1.
- R5: A read of any of the four half-registers returns its 16 stored bits in bits 15:0 and 0 in bits 31:16.
- R6: A read of offset 0x70 returns the level of all 32 `pin_in` bits in pin order. The value is the one sampled at the clock edge two edges earlier, because of the two-stage synchronizer.
- R7: A read of offset 0x78 returns the constant identifier 0x01012306, which is nonzero.
- R8: A read of any offset other than the six above returns 0. A write to such an offset, or to 0x70 or 0x78, changes neither `pin_out` nor `pin_oe`. When no read is presented (select low, or write strobe high), `rd_data` is 0.
- R9: A write with all sixteen mask bits clear leaves the addressed half-register unchanged, whatever its low sixteen bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_sel | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of the register |
| wr_data | input | 32 | Write word: bits 31:16 are the mask, bits 15:0 are the values |
| rd_data | output | 32 | Read word, valid in the cycle of the read |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output levels of the pins |
| pin_oe | output | 32 | Output enables, 1 = pin driven |

## Verification
The assertions assume that `acc_addr`, `acc_sel`, `acc_wr` and `wr_data` only change away from the rising clock edge. The synchronizer assertion also assumes that `pin_in` stays constant at each rising edge, which is a stronger condition than real asynchronous pins give. The bench drives every input, `pin_in` included, shortly after the falling edge. It holds `pin_in` at zero and issues no accesses until the internal reset has been released.

The checker itself stays inactive for the first few cycles after reset is released. This covers the time the design is still held in reset internally and the synchronizer is still filling. The random phase mixes full, partial and empty masks over mapped and unmapped offsets while `pin_in` changes every cycle, so that readback and synchronizer latency are compared against the model on every clock.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam int BUS_W    = 32;
  localparam int HALF_W   = BUS_W / 2;
  localparam int ADDR_W   = 8;
  localparam int PIN_W    = 32;
  localparam int NUM_HALF = PIN_W / HALF_W;
  localparam int LVL_BASE = 'h00;
  localparam int DIR_BASE = LVL_BASE + 4 * NUM_HALF;
  localparam int SMP_OFS  = 'h70;
  localparam int ID_OFS   = 'h78;
  localparam logic [BUS_W-1:0] ID_VALUE = 32'h0101_2306;

  function automatic logic is_half_ofs(input logic [ADDR_W-1:0] a);
    return (int'(a) >= LVL_BASE) && (int'(a) < DIR_BASE + 4 * NUM_HALF) && (a[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/gpio_mw_rst_sync.sv
module gpio_mw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/gpio_mw_half_reg.sv
module gpio_mw_half_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2*W-1:0] wr_word,
  output logic [W-1:0] q
);
  logic [W-1:0] mask;
  logic [W-1:0] val;
  logic [W-1:0] q_nxt;

  assign mask = wr_word[2*W-1:W];
  assign val  = wr_word[W-1:0];

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = (q & ~mask) | (val & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/gpio_mw_in_sync.sv
module gpio_mw_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = async_in;
      end else begin : g_next
        assign stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BUS_W-1:0] ID_CONST = ID_VALUE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic rst_n_int;
  logic wr_acc;
  logic rd_acc;
  logic [NUM_HALF-1:0] lvl_we;
  logic [NUM_HALF-1:0] dir_we;
  logic [NUM_HALF-1:0][HALF_W-1:0] lvl_half;
  logic [NUM_HALF-1:0][HALF_W-1:0] dir_half;
  logic [PIN_W-1:0] smp_lvl;
  logic [BUS_W-1:0] rd_mux;

  gpio_mw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign wr_acc = acc_sel & acc_wr;
  assign rd_acc = acc_sel & ~acc_wr;

  generate
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
      assign lvl_we[h] = wr_acc && (acc_addr == ADDR_W'(LVL_BASE + 4 * h));
      assign dir_we[h] = wr_acc && (acc_addr == ADDR_W'(DIR_BASE + 4 * h));

      gpio_mw_half_reg #(.W(HALF_W)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n_int),
        .wr_en   (lvl_we[h]),
        .wr_word (wr_data),
        .q       (lvl_half[h])
      );

      gpio_mw_half_reg #(.W(HALF_W)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n_int),
        .wr_en   (dir_we[h]),
        .wr_word (wr_data),
        .q       (dir_half[h])
      );
    end
  endgenerate

  gpio_mw_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in (pin_in),
    .sync_out (smp_lvl)
  );

  always_comb begin
    rd_mux = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (acc_addr == ADDR_W'(LVL_BASE + 4 * h)) rd_mux = {{(BUS_W-HALF_W){1'b0}}, lvl_half[h]};
      if (acc_addr == ADDR_W'(DIR_BASE + 4 * h)) rd_mux = {{(BUS_W-HALF_W){1'b0}}, dir_half[h]};
    end
    if (acc_addr == ADDR_W'(SMP_OFS)) rd_mux = BUS_W'(smp_lvl);
    if (acc_addr == ADDR_W'(ID_OFS))  rd_mux = ID_CONST;
  end

  assign rd_data = rd_acc ? rd_mux : '0;
  assign pin_out = lvl_half;
  assign pin_oe  = dir_half;
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk
  import gpio_mw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_sel,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [BUS_W-1:0]  wr_data,
  input logic [BUS_W-1:0]  rd_data,
  input logic [PIN_W-1:0]  pin_in,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe
);
  logic [2:0] up_cnt;
  logic armed;
  logic wr_c;
  logic rd_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           up_cnt <= 3'd0;
    else if (up_cnt != 3'd6) up_cnt <= up_cnt + 3'd1;
  end

  assign armed = (up_cnt == 3'd6);
  assign wr_c  = acc_sel & acc_wr;
  assign rd_c  = acc_sel & ~acc_wr;

  // R9
  mask_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_c && acc_addr == 8'h00 && wr_data[31:16] == 16'h0) |=> $stable(pin_out[15:0]));

  // R3
  lvl_hi_map_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_c && acc_addr == 8'h04 && wr_data[31:16] == 16'hFFFF) |=> (pin_out[31:16] == $past(wr_data[15:0])));

  // R4
  dir_lo_map_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_c && acc_addr == 8'h08 && wr_data[31:16] == 16'hFFFF) |=> (pin_oe[15:0] == $past(wr_data[15:0])));

  // R2
  lvl_lo_masked_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_c && acc_addr == 8'h00) |=>
      (pin_out[15:0] == (($past(pin_out[15:0]) & ~$past(wr_data[31:16])) | ($past(wr_data[15:0]) & $past(wr_data[31:16])))));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_c && !is_half_ofs(acc_addr)) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R5
  half_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_c && is_half_ofs(acc_addr)) |-> (rd_data[31:16] == 16'h0));

  // R6
  smp_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_c && acc_addr == 8'h70) |-> (rd_data == $past(pin_in, 2)));

  // R7
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_c && acc_addr == 8'h78) |-> (rd_data == ID_VALUE));
endmodule

bind gpio_mw_bank gpio_mw_bank_chk u_chk (.*);

// File: tb/test_gpio_mw_bank.sv
`timescale 1ns/100ps
module test_gpio_mw_bank;
  logic        clk;
  logic        rst_n;
  logic        acc_sel;
  logic        acc_wr;
  logic [7:0]  acc_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_lvl;
  logic [31:0] m_dir;
  logic [31:0] m_hist[$];

  gpio_mw_bank i_gpio_mw_bank (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] apply_mask(input logic [15:0] old, input logic [31:0] w);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = w[k+16] ? w[k] : old[k];
    return r;
  endfunction

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 0; m_dir = 0; m_hist.delete();
    end else begin
      if (acc_sel && acc_wr) begin
        case (acc_addr)
          8'h00: m_lvl[15:0]  = apply_mask(m_lvl[15:0],  wr_data);
          8'h04: m_lvl[31:16] = apply_mask(m_lvl[31:16], wr_data);
          8'h08: m_dir[15:0]  = apply_mask(m_dir[15:0],  wr_data);
          8'h0C: m_dir[31:16] = apply_mask(m_dir[31:16], wr_data);
          default: ;
        endcase
      end
      m_hist.push_front(pin_in);
      if (m_hist.size() > 2) void'(m_hist.pop_back());
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {16'h0, m_lvl[15:0]};
      8'h04: return {16'h0, m_lvl[31:16]};
      8'h08: return {16'h0, m_dir[15:0]};
      8'h0C: return {16'h0, m_dir[31:16]};
      8'h70: return (m_hist.size() == 2) ? m_hist[1] : 32'h0;
      8'h78: return 32'h0101_2306;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R3";
      8'h08, 8'h0C: return "R5";
      8'h70: return "R6";
      8'h78: return "R7";
      default: return "R8";
    endcase
  endfunction

  // one bus cycle: drive after the falling edge, compare 1 ns later
  task automatic cyc(input logic s, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    acc_sel = s; acc_wr = w; acc_addr = a; wr_data = d; pin_in = p;
    #1;
    check("R4 pin_out", pin_out, m_lvl);
    check("R4 pin_oe", pin_oe, m_dir);
    if (s && !w) check(read_tag(a), rd_data, exp_read(a));
    else         check("R8 idle rd_data", rd_data, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, pin_in);
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(1'b1, 1'b0, a, 32'h0, pin_in);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_sel = 0; acc_wr = 0; acc_addr = 0; wr_data = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    #1;
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);

    // R3 full-mask writes, both halves
    wr(8'h00, 32'hFFFF_A5C3);
    wr(8'h04, 32'hFFFF_3C96);
    rd(8'h00); rd(8'h04);
    check("R3 pin_out pattern", pin_out, 32'h3C96_A5C3);

    // R2 partial mask: only bits 0 and 15 of low half
    wr(8'h00, 32'h8001_0000);
    rd(8'h00);
    check("R2 partial mask", pin_out, 32'h3C96_25C2);

    // R9 zero mask leaves register as is
    wr(8'h04, 32'h0000_FFFF);
    rd(8'h04);
    check("R9 zero mask", pin_out, 32'h3C96_25C2);

    // R4 directions
    wr(8'h08, 32'hFFFF_00FF);
    wr(8'h0C, 32'h0F00_0A00);
    rd(8'h08); rd(8'h0C);
    check("R4 oe pattern", pin_oe, 32'h0A00_00FF);

    // R8 unmapped and read-only writes
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h10); rd(8'h74); rd(8'hFC); rd(8'h00);
    cyc(1'b0, 1'b0, 8'h78, 32'h0, pin_in);

    // R6 sampled inputs with latency, R7 identifier
    cyc(1'b1, 1'b0, 8'h70, 32'h0, 32'hDEAD_BEEF);
    cyc(1'b1, 1'b0, 8'h70, 32'h0, 32'h1234_5678);
    cyc(1'b1, 1'b0, 8'h70, 32'h0, 32'h1234_5678);
    cyc(1'b1, 1'b0, 8'h70, 32'h0, 32'h1234_5678);
    rd(8'h78);

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      logic [7:0] a;
      r = $urandom;
      case (r[3:0])
        4'd0, 4'd1, 4'd2: a = 8'h00;
        4'd3, 4'd4:       a = 8'h04;
        4'd5, 4'd6:       a = 8'h08;
        4'd7:             a = 8'h0C;
        4'd8, 4'd9:       a = 8'h70;
        4'd10:            a = 8'h78;
        default:          a = {r[9:4], 2'b00};
      endcase
      cyc(r[10], r[11], a, $urandom, $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule